// File: doc/BRIEF.md
# Interrupt Stack Frame Push Sequencer

This block runs once the dispatch logic has settled where an interrupt or exception goes. It builds the return frame by emitting one stack write per cycle, from the highest address down. When the frame is complete it presents the values the core commits: entry instruction pointer, code selector, stack selector and pointer, flags and privilege level. It handles three entry kinds. Real-mode entry fetches its target from a table of 4-byte vectors. Protected-mode entry at the current privilege keeps the current stack. Protected-mode entry to a more privileged level switches to a new stack and, when the interrupted code ran in virtual-8086 mode, also saves the four data segment selectors.

Before any write, one check cycle tests two things: that the chosen stack has room for the whole frame, and, in protected mode, that the target pointer lies within the code segment limit. If either test fails the sequencer raises a fault pulse and writes nothing. The stack fault takes priority over the limit fault.

The state machine walks these states: ST_IDLE; ST_RD_IP and ST_RD_CS for the two table reads; ST_CHECK; the push states ST_GS, ST_FS, ST_DS, ST_ES, ST_SS, ST_SP, ST_FL, ST_CS, ST_IP, ST_ERR; then ST_DONE or ST_FAULT. The transitions are:
- ST_IDLE goes to ST_RD_IP on start for real mode, and to ST_CHECK otherwise.
- ST_RD_IP goes to ST_RD_CS, which goes to ST_CHECK.
- ST_CHECK goes to ST_FAULT on a failed test. Otherwise it goes to ST_GS for a virtual-8086 entry, to ST_SS for any other privilege increase, and to ST_FL in all other cases.
- The push states follow one another in the order listed. ST_IP goes to ST_ERR when an error code is present, and to ST_DONE otherwise.
- ST_ERR goes to ST_DONE.
- ST_DONE and ST_FAULT return to ST_IDLE.

Top module: `intr_frame_seq`

## Requirements
- R1: In real mode the block reads the table twice, on the two cycles after start. The first read is at vector×4 and returns the new IP. The second is at vector×4+2 and returns the new CS.
- R2: Real-mode frame: writes of flags, old CS and old IP, in that order. No error code is written even when one is flagged. No code-limit test is made. The committed flags have IF (bit 9) and TF (bit 8) cleared.
- R3: When the entry is caused by a fault, the written flags value has bit 16 set.
- R4: Same-privilege entry (kind 1, and kind 3 behaves the same) writes flags, old CS, old IP and then the error code if present, on the current stack.
- R5: Entry to a more privileged level (kind 2) writes on the new stack, starting from the new stack pointer. The order is GS, FS, DS and ES (virtual-8086 only), then old SS, old SP, flags, old CS, old IP, and the error code if present.
- R6: The frame needs 3 items in real mode. In protected mode it needs 3 items at the same level, or 5 items on a privilege increase (9 from virtual-8086), plus one item for an error code. If the chosen stack pointer is below items×width, ss_fault pulses and nothing is written.
- R7: In protected mode, if the stack has room and the target IP exceeds the code limit, gp_fault pulses and nothing is written.
- R8: In protected mode the committed flags have TF (bit 8) and NT (bit 14) cleared. IF (bit 9) is cleared only for an interrupt gate. On a privilege increase VM (bit 17) is also cleared.
- R9: In protected mode the committed CS has bits [1:0] replaced by the privilege level after entry. That level is the current level at the same privilege, and the target level on a privilege increase.
- R10: null_segs is high together with done only for a virtual-8086 entry.
- R11: Each write is 4 bytes when op32 is set and 2 bytes otherwise. Its address is the stack pointer already reduced by that size. Selectors are zero-extended, and 16-bit writes carry only the low half.
- R12: done pulses for one cycle right after the last write. entry_sp then equals the starting pointer minus the frame size.
- R13: After reset all strobes are low. A start seen while a frame is in progress is ignored, and inputs changed mid-frame do not alter the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| start | input | 1 | begin a frame (taken in ST_IDLE) |
| kind | input | 2 | 0 real, 1 same level, 2 more privileged, 3 as 1 |
| op32 | input | 1 | 32-bit operand size |
| intr_gate | input | 1 | 1 interrupt gate, 0 trap gate |
| is_fault | input | 1 | entry caused by a fault |
| has_err | input | 1 | error code present |
| err_code | input | 16 | error code value |
| from_v86 | input | 1 | interrupted code was virtual-8086 |
| vector | input | VEC_W | vector number |
| cur_cpl | input | 2 | current privilege level |
| tgt_dpl | input | 2 | target privilege level |
| old_flags | input | 32 | flags before entry |
| old_cs | input | 16 | code selector before entry |
| old_ip | input | 32 | return pointer |
| old_ss | input | 16 | stack selector before entry |
| old_sp | input | 32 | stack pointer before entry |
| old_ds | input | 16 | DS selector |
| old_es | input | 16 | ES selector |
| old_fs | input | 16 | FS selector |
| old_gs | input | 16 | GS selector |
| gate_cs | input | 16 | target code selector from the gate |
| gate_ip | input | 32 | target pointer from the gate |
| cs_limit | input | 32 | target code segment limit |
| new_ss | input | 16 | new stack selector |
| new_sp | input | 32 | new stack pointer |
| rd_en | output | 1 | table read strobe |
| rd_addr | output | 32 | table read address |
| rd_data | input | 16 | table read data, same cycle |
| push_valid | output | 1 | stack write strobe |
| push_wide | output | 1 | write is 4 bytes |
| push_addr | output | 32 | write address |
| push_data | output | 32 | write data |
| gp_fault | output | 1 | code limit fault pulse |
| ss_fault | output | 1 | stack room fault pulse |
| done | output | 1 | frame complete pulse |
| entry_ip | output | 32 | new IP (valid with done) |
| entry_cs | output | 16 | new CS (valid with done) |
| entry_ss | output | 16 | new SS (valid with done) |
| entry_sp | output | 32 | new SP (valid with done) |
| entry_flags | output | 32 | new flags (valid with done) |
| entry_cpl | output | 2 | new privilege level (valid with done) |
| null_segs | output | 1 | load null into GS, FS, DS, ES |

## Verification
The assertions assume several things about the inputs. The table memory answers in the same cycle. Inputs are stable only at the start edge, since they are latched then. The operand size stays fixed for the whole frame. The bench meets these assumptions: it models the table as combinational logic of the address, and it raises start only from idle. It also changes inputs and pulses start again partway through one frame, to show that the latched copy alone drives the writes. The stack-room and code-limit cases are set exactly at, and one step past, their boundaries.

// File: rtl/intr_frame_pkg.sv
package intr_frame_pkg;

    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;
    localparam int SEL_W  = 16;
    localparam int CPL_W  = 2;

    localparam int BIT_TF = 8;
    localparam int BIT_IF = 9;
    localparam int BIT_NT = 14;
    localparam int BIT_RF = 16;
    localparam int BIT_VM = 17;

    typedef enum logic [1:0] {
        ENT_REAL = 2'd0,
        ENT_SAME = 2'd1,
        ENT_MORE = 2'd2,
        ENT_RSVD = 2'd3
    } entry_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RD_IP, ST_RD_CS, ST_CHECK,
        ST_GS, ST_FS, ST_DS, ST_ES,
        ST_SS, ST_SP, ST_FL, ST_CS,
        ST_IP, ST_ERR, ST_DONE, ST_FAULT
    } state_e;

    typedef struct packed {
        entry_e              kind;
        logic                op32;
        logic                intr_gate;
        logic                is_fault;
        logic                has_err;
        logic                from_v86;
        logic [SEL_W-1:0]    err;
        logic [CPL_W-1:0]    cur_cpl;
        logic [CPL_W-1:0]    tgt_dpl;
        logic [WORD_W-1:0]   flags;
        logic [SEL_W-1:0]    cs;
        logic [ADDR_W-1:0]   ip;
        logic [SEL_W-1:0]    ss;
        logic [ADDR_W-1:0]   sp;
        logic [SEL_W-1:0]    ds;
        logic [SEL_W-1:0]    es;
        logic [SEL_W-1:0]    fs;
        logic [SEL_W-1:0]    gs;
        logic [SEL_W-1:0]    gcs;
        logic [ADDR_W-1:0]   gip;
        logic [ADDR_W-1:0]   cs_lim;
        logic [SEL_W-1:0]    nss;
        logic [ADDR_W-1:0]   nsp;
    } req_t;

endpackage

// File: rtl/intr_frame_budget.sv
module intr_frame_budget
    import intr_frame_pkg::*;
(
    input  req_t              req,
    input  logic [ADDR_W-1:0] tgt_ip,
    output logic [ADDR_W-1:0] base_sp,
    output logic [ADDR_W-1:0] step,
    output logic              room_ok,
    output logic              ip_ok
);
    localparam int CNT_W      = 4;
    localparam int ITEMS_BASE = 3;
    localparam int ITEMS_PRIV = 5;
    localparam int ITEMS_V86  = 9;

    logic [CNT_W-1:0]  items;
    logic [ADDR_W-1:0] need;

    always_comb begin
        case (req.kind)
            ENT_REAL: items = CNT_W'(ITEMS_BASE);
            ENT_MORE: items = req.from_v86 ? CNT_W'(ITEMS_V86) : CNT_W'(ITEMS_PRIV);
            default:  items = CNT_W'(ITEMS_BASE);
        endcase
        if (req.kind != ENT_REAL && req.has_err)
            items = items + CNT_W'(1);
    end

    assign step    = req.op32 ? ADDR_W'(4) : ADDR_W'(2);
    assign need    = ADDR_W'(items) << (req.op32 ? 2 : 1);
    assign base_sp = (req.kind == ENT_MORE) ? req.nsp : req.sp;
    assign room_ok = (base_sp >= need);
    assign ip_ok   = (req.kind == ENT_REAL) || (tgt_ip <= req.cs_lim);

endmodule

// File: rtl/intr_push_mux.sv
module intr_push_mux
    import intr_frame_pkg::*;
(
    input  state_e            state,
    input  req_t              req,
    output logic              active,
    output logic [WORD_W-1:0] data
);
    localparam int PAD_W = WORD_W - SEL_W;

    logic [WORD_W-1:0] raw;
    logic [WORD_W-1:0] fl_word;

    assign fl_word = req.flags | (req.is_fault ? (WORD_W'(1) << BIT_RF) : '0);

    always_comb begin
        active = 1'b1;
        unique case (state)
            ST_GS:   raw = {{PAD_W{1'b0}}, req.gs};
            ST_FS:   raw = {{PAD_W{1'b0}}, req.fs};
            ST_DS:   raw = {{PAD_W{1'b0}}, req.ds};
            ST_ES:   raw = {{PAD_W{1'b0}}, req.es};
            ST_SS:   raw = {{PAD_W{1'b0}}, req.ss};
            ST_SP:   raw = req.sp;
            ST_FL:   raw = fl_word;
            ST_CS:   raw = {{PAD_W{1'b0}}, req.cs};
            ST_IP:   raw = req.ip;
            ST_ERR:  raw = {{PAD_W{1'b0}}, req.err};
            default: begin
                raw    = '0;
                active = 1'b0;
            end
        endcase
    end

    assign data = req.op32 ? raw : {{PAD_W{1'b0}}, raw[SEL_W-1:0]};

endmodule

// File: rtl/intr_exit_calc.sv
module intr_exit_calc
    import intr_frame_pkg::*;
(
    input  req_t              req,
    input  logic [SEL_W-1:0]  tbl_ip,
    input  logic [SEL_W-1:0]  tbl_cs,
    output logic [ADDR_W-1:0] entry_ip,
    output logic [SEL_W-1:0]  entry_cs,
    output logic [SEL_W-1:0]  entry_ss,
    output logic [CPL_W-1:0]  entry_cpl,
    output logic [WORD_W-1:0] entry_flags,
    output logic              clr_segs
);
    logic [WORD_W-1:0] clr_mask;

    always_comb begin
        clr_mask = (WORD_W'(1) << BIT_TF);
        clr_segs = 1'b0;
        case (req.kind)
            ENT_REAL: begin
                entry_ip  = ADDR_W'(tbl_ip);
                entry_cs  = tbl_cs;
                entry_ss  = req.ss;
                entry_cpl = req.cur_cpl;
                clr_mask  = clr_mask | (WORD_W'(1) << BIT_IF);
            end
            ENT_MORE: begin
                entry_ip  = req.gip;
                entry_cs  = {req.gcs[SEL_W-1:CPL_W], req.tgt_dpl};
                entry_ss  = req.nss;
                entry_cpl = req.tgt_dpl;
                clr_segs  = req.from_v86;
                clr_mask  = clr_mask | (WORD_W'(1) << BIT_NT) | (WORD_W'(1) << BIT_VM)
                          | (req.intr_gate ? (WORD_W'(1) << BIT_IF) : '0);
            end
            default: begin
                entry_ip  = req.gip;
                entry_cs  = {req.gcs[SEL_W-1:CPL_W], req.cur_cpl};
                entry_ss  = req.ss;
                entry_cpl = req.cur_cpl;
                clr_mask  = clr_mask | (WORD_W'(1) << BIT_NT)
                          | (req.intr_gate ? (WORD_W'(1) << BIT_IF) : '0);
            end
        endcase
        entry_flags = req.flags & ~clr_mask;
    end

endmodule

// File: rtl/intr_frame_seq.sv
module intr_frame_seq
    import intr_frame_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        kind,
    input  logic              op32,
    input  logic              intr_gate,
    input  logic              is_fault,
    input  logic              has_err,
    input  logic [15:0]       err_code,
    input  logic              from_v86,
    input  logic [VEC_W-1:0]  vector,
    input  logic [1:0]        cur_cpl,
    input  logic [1:0]        tgt_dpl,
    input  logic [31:0]       old_flags,
    input  logic [15:0]       old_cs,
    input  logic [31:0]       old_ip,
    input  logic [15:0]       old_ss,
    input  logic [31:0]       old_sp,
    input  logic [15:0]       old_ds,
    input  logic [15:0]       old_es,
    input  logic [15:0]       old_fs,
    input  logic [15:0]       old_gs,
    input  logic [15:0]       gate_cs,
    input  logic [31:0]       gate_ip,
    input  logic [31:0]       cs_limit,
    input  logic [15:0]       new_ss,
    input  logic [31:0]       new_sp,
    output logic              rd_en,
    output logic [31:0]       rd_addr,
    input  logic [15:0]       rd_data,
    output logic              push_valid,
    output logic              push_wide,
    output logic [31:0]       push_addr,
    output logic [31:0]       push_data,
    output logic              gp_fault,
    output logic              ss_fault,
    output logic              done,
    output logic [31:0]       entry_ip,
    output logic [15:0]       entry_cs,
    output logic [15:0]       entry_ss,
    output logic [31:0]       entry_sp,
    output logic [31:0]       entry_flags,
    output logic [1:0]        entry_cpl,
    output logic              null_segs
);
    localparam int TBL_SH   = 2;
    localparam int HALF_OFS = 2;

    state_e            state_q, state_d;
    req_t              req_q, req_in;
    logic [VEC_W-1:0]  vec_q;
    logic [SEL_W-1:0]  tbl_ip_q, tbl_cs_q;
    logic [ADDR_W-1:0] sp_q;

    logic [ADDR_W-1:0] base_sp, step, tgt_ip;
    logic              room_ok, ip_ok;
    logic              push_act;
    logic [WORD_W-1:0] push_word;
    logic              clr_segs;

    always_comb begin
        req_in.kind      = entry_e'(kind);
        req_in.op32      = op32;
        req_in.intr_gate = intr_gate;
        req_in.is_fault  = is_fault;
        req_in.has_err   = has_err;
        req_in.from_v86  = from_v86;
        req_in.err       = err_code;
        req_in.cur_cpl   = cur_cpl;
        req_in.tgt_dpl   = tgt_dpl;
        req_in.flags     = old_flags;
        req_in.cs        = old_cs;
        req_in.ip        = old_ip;
        req_in.ss        = old_ss;
        req_in.sp        = old_sp;
        req_in.ds        = old_ds;
        req_in.es        = old_es;
        req_in.fs        = old_fs;
        req_in.gs        = old_gs;
        req_in.gcs       = gate_cs;
        req_in.gip       = gate_ip;
        req_in.cs_lim    = cs_limit;
        req_in.nss       = new_ss;
        req_in.nsp       = new_sp;
    end

    intr_exit_calc u_exit (
        .req         (req_q),
        .tbl_ip      (tbl_ip_q),
        .tbl_cs      (tbl_cs_q),
        .entry_ip    (tgt_ip),
        .entry_cs    (entry_cs),
        .entry_ss    (entry_ss),
        .entry_cpl   (entry_cpl),
        .entry_flags (entry_flags),
        .clr_segs    (clr_segs)
    );

    intr_frame_budget u_budget (
        .req     (req_q),
        .tgt_ip  (tgt_ip),
        .base_sp (base_sp),
        .step    (step),
        .room_ok (room_ok),
        .ip_ok   (ip_ok)
    );

    intr_push_mux u_mux (
        .state  (state_q),
        .req    (req_q),
        .active (push_act),
        .data   (push_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // latched request, table words and running stack pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q    <= '0;
            vec_q    <= '0;
            tbl_ip_q <= '0;
            tbl_cs_q <= '0;
            sp_q     <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                req_q <= req_in;
                vec_q <= vector;
            end
            if (state_q == ST_RD_IP) tbl_ip_q <= rd_data;
            if (state_q == ST_RD_CS) tbl_cs_q <= rd_data;
            if (state_q == ST_CHECK)  sp_q <= base_sp;
            else if (push_act)        sp_q <= sp_q - step;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = (entry_e'(kind) == ENT_REAL) ? ST_RD_IP : ST_CHECK;
            ST_RD_IP: state_d = ST_RD_CS;
            ST_RD_CS: state_d = ST_CHECK;
            ST_CHECK: begin
                if (!room_ok || !ip_ok)                           state_d = ST_FAULT;
                else if (req_q.kind == ENT_MORE && req_q.from_v86) state_d = ST_GS;
                else if (req_q.kind == ENT_MORE)                   state_d = ST_SS;
                else                                               state_d = ST_FL;
            end
            ST_GS:    state_d = ST_FS;
            ST_FS:    state_d = ST_DS;
            ST_DS:    state_d = ST_ES;
            ST_ES:    state_d = ST_SS;
            ST_SS:    state_d = ST_SP;
            ST_SP:    state_d = ST_FL;
            ST_FL:    state_d = ST_CS;
            ST_CS:    state_d = ST_IP;
            ST_IP:    state_d = (req_q.kind != ENT_REAL && req_q.has_err) ? ST_ERR : ST_DONE;
            ST_ERR:   state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_en      = 1'b0;
        rd_addr    = ADDR_W'(vec_q) << TBL_SH;
        done       = 1'b0;
        gp_fault   = 1'b0;
        ss_fault   = 1'b0;
        null_segs  = 1'b0;
        unique case (state_q)
            ST_RD_IP: rd_en = 1'b1;
            ST_RD_CS: begin
                rd_en   = 1'b1;
                rd_addr = (ADDR_W'(vec_q) << TBL_SH) + ADDR_W'(HALF_OFS);
            end
            ST_DONE: begin
                done      = 1'b1;
                null_segs = clr_segs;
            end
            ST_FAULT: begin
                ss_fault = !room_ok;
                gp_fault = room_ok && !ip_ok;
            end
            default: ;
        endcase
    end

    assign push_valid = push_act;
    assign push_wide  = req_q.op32;
    assign push_addr  = sp_q - step;
    assign push_data  = push_word;
    assign entry_ip   = tgt_ip;
    assign entry_sp   = sp_q;

    // each write sits one item below the previous one
    assert_sp_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && $past(push_valid)) |-> (push_addr == $past(push_addr) - (push_wide ? 32'd4 : 32'd2)));

    // second table read follows the first, one half-word up
    assert_tbl_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 32'd2));

    // strobes never overlap
    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push_valid, done, gp_fault, ss_fault, rd_en}));

    // a fault is never followed by a write
    assert_fault_nopush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gp_fault || ss_fault) |=> !push_valid);

    // committed target respects the code limit in protected mode
    assert_limit_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && req_q.kind != ENT_REAL) |-> (entry_ip <= req_q.cs_lim));

    // trap flag always cleared on entry
    assert_tf_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !entry_flags[BIT_TF]);

    // selector RPL matches the level after entry
    assert_rpl_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && req_q.kind != ENT_REAL) |-> (entry_cs[1:0] == entry_cpl));

    // done only right after the final write
    assert_done_after_push_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(push_valid));

endmodule

// File: tb/intr_frame_seq_tb.sv
`timescale 1ns/1ps
module intr_frame_seq_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        start = 0, op32 = 0, intr_gate = 0, is_fault = 0, has_err = 0, from_v86 = 0;
    logic [1:0]  kind = 0, cur_cpl = 0, tgt_dpl = 0;
    logic [15:0] err_code = 0, old_cs = 0, old_ss = 0, old_ds = 0, old_es = 0, old_fs = 0, old_gs = 0;
    logic [15:0] gate_cs = 0, new_ss = 0;
    logic [7:0]  vector = 0;
    logic [31:0] old_flags = 0, old_ip = 0, old_sp = 0, gate_ip = 0, cs_limit = 0, new_sp = 0;
    logic        rd_en, push_valid, push_wide, gp_fault, ss_fault, done, null_segs;
    logic [31:0] rd_addr, push_addr, push_data, entry_ip, entry_sp, entry_flags;
    logic [15:0] rd_data, entry_cs, entry_ss;
    logic [1:0]  entry_cpl;

    function automatic logic [15:0] memw(input logic [31:0] a);
        return (a[15:0] * 16'h9E37) ^ 16'h5A3C;
    endfunction
    assign rd_data = memw(rd_addr);

    intr_frame_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .op32(op32),
        .intr_gate(intr_gate), .is_fault(is_fault), .has_err(has_err), .err_code(err_code),
        .from_v86(from_v86), .vector(vector), .cur_cpl(cur_cpl), .tgt_dpl(tgt_dpl),
        .old_flags(old_flags), .old_cs(old_cs), .old_ip(old_ip), .old_ss(old_ss), .old_sp(old_sp),
        .old_ds(old_ds), .old_es(old_es), .old_fs(old_fs), .old_gs(old_gs),
        .gate_cs(gate_cs), .gate_ip(gate_ip), .cs_limit(cs_limit), .new_ss(new_ss), .new_sp(new_sp),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .push_valid(push_valid), .push_wide(push_wide), .push_addr(push_addr), .push_data(push_data),
        .gp_fault(gp_fault), .ss_fault(ss_fault), .done(done),
        .entry_ip(entry_ip), .entry_cs(entry_cs), .entry_ss(entry_ss), .entry_sp(entry_sp),
        .entry_flags(entry_flags), .entry_cpl(entry_cpl), .null_segs(null_segs)
    );

    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        logic        wide;
        string       tag;
    } exp_push_t;

    exp_push_t   pq[$];
    logic [31:0] rq[$];
    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor: pops expected items as the design emits them
    always @(negedge clk) begin
        if (rst_n) begin
            if (push_valid) begin
                if (pq.size() == 0) begin
                    chk("R6", "unexpected push", push_addr, 32'hFFFF_FFFF);
                end else begin
                    exp_push_t e;
                    e = pq.pop_front();
                    chk(e.tag, "push addr R11", push_addr, e.addr);
                    chk(e.tag, "push data", push_data, e.data);
                    chk(e.tag, "push width R11", {31'b0, push_wide}, {31'b0, e.wide});
                end
            end
            if (rd_en) begin
                if (rq.size() == 0) chk("R1", "unexpected read", rd_addr, 32'hFFFF_FFFF);
                else chk("R1", "table addr", rd_addr, rq.pop_front());
            end
        end
    end

    task automatic defaults();
        kind = 0; op32 = 0; intr_gate = 1; is_fault = 0; has_err = 0; from_v86 = 0;
        err_code = 16'h0E42; vector = 8'h21; cur_cpl = 2'd3; tgt_dpl = 2'd0;
        old_flags = 32'h0002_4302; old_cs = 16'h1B2F; old_ip = 32'h0040_1234;
        old_ss = 16'h23A7; old_sp = 32'h0000_8000;
        old_ds = 16'h2B11; old_es = 16'h3C22; old_fs = 16'h4D33; old_gs = 16'h5E44;
        gate_cs = 16'h0008; gate_ip = 32'h0001_0800; cs_limit = 32'h000F_FFFF;
        new_ss = 16'h0010; new_sp = 32'h0001_0000;
    endtask

    // driver: builds the expected frame, starts the block, checks the exit values
    task automatic go(input string tag, input bit poke);
        logic [31:0] sp, step, ip_t, vals[$], fl_x, clr;
        logic [15:0] cs_t, ss_t;
        logic [1:0]  cpl_t;
        int          items;
        bit          ss_f, gp_f, seen;
        step = op32 ? 32'd4 : 32'd2;
        vals.delete();
        if (kind == 2'd0) begin
            rq.push_back({22'b0, vector, 2'b00});
            rq.push_back({22'b0, vector, 2'b00} + 32'd2);
            ip_t = {16'b0, memw({22'b0, vector, 2'b00})};
            cs_t = memw({22'b0, vector, 2'b00} + 32'd2);
            items = 3; sp = old_sp; cpl_t = cur_cpl; ss_t = old_ss;
            clr = 32'h0000_0300;
        end else begin
            ip_t = gate_ip;
            items = (kind == 2'd2) ? (from_v86 ? 9 : 5) : 3;
            if (has_err) items++;
            sp = (kind == 2'd2) ? new_sp : old_sp;
            cpl_t = (kind == 2'd2) ? tgt_dpl : cur_cpl;
            ss_t = (kind == 2'd2) ? new_ss : old_ss;
            cs_t = {gate_cs[15:2], cpl_t};
            clr = 32'h0000_4100 | (intr_gate ? 32'h200 : 32'h0) | ((kind == 2'd2) ? 32'h0002_0000 : 32'h0);
        end
        ss_f = (sp < items * step);
        gp_f = !ss_f && (kind != 2'd0) && (ip_t > cs_limit);
        if (!ss_f && !gp_f) begin
            if (kind == 2'd2 && from_v86) begin
                vals.push_back({16'b0, old_gs}); vals.push_back({16'b0, old_fs});
                vals.push_back({16'b0, old_ds}); vals.push_back({16'b0, old_es});
            end
            if (kind == 2'd2) begin
                vals.push_back({16'b0, old_ss}); vals.push_back(old_sp);
            end
            vals.push_back(old_flags | (is_fault ? 32'h0001_0000 : 32'h0));
            vals.push_back({16'b0, old_cs});
            vals.push_back(old_ip);
            if (kind != 2'd0 && has_err) vals.push_back({16'b0, err_code});
            foreach (vals[i]) begin
                sp = sp - step;
                pq.push_back('{sp, op32 ? vals[i] : {16'b0, vals[i][15:0]}, op32, tag});
            end
        end
        fl_x = old_flags & ~clr;

        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        seen = 0;
        for (int c = 0; c < 40; c++) begin
            if (done || gp_fault || ss_fault) begin seen = 1; break; end
            if (poke && c == 1) begin start = 1'b1; old_flags = ~old_flags; old_ip = 32'hDEAD_0000; end
            if (poke && c == 2) start = 1'b0;
            @(negedge clk);
        end
        if (!seen) chk("R12", "frame end (watchdog)", 32'd0, 32'd1);
        chk("R6", "ss_fault", {31'b0, ss_fault}, {31'b0, ss_f});
        chk("R7", "gp_fault", {31'b0, gp_fault}, {31'b0, gp_f});
        chk("R12", "done", {31'b0, done}, {31'b0, !(ss_f || gp_f)});
        if (done) begin
            chk("R9", "entry_ip", entry_ip, ip_t);
            chk("R9", "entry_cs", {16'b0, entry_cs}, {16'b0, cs_t});
            chk("R9", "entry_cpl", {30'b0, entry_cpl}, {30'b0, cpl_t});
            chk("R5", "entry_ss", {16'b0, entry_ss}, {16'b0, ss_t});
            chk("R12", "entry_sp", entry_sp, sp);
            chk("R8", "entry_flags", entry_flags, fl_x);
            chk("R10", "null_segs", {31'b0, null_segs}, {31'b0, kind == 2'd2 && from_v86});
        end
        chk(tag, "pushes left over", pq.size(), 0);
        pq.delete(); rq.delete();
        @(negedge clk);
        chk("R12", "done is a pulse", {31'b0, done}, 32'd0);
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++; n_bad++;
        $display("FAIL R12 watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        defaults();
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13", "strobes in reset", {27'b0, push_valid, done, gp_fault, ss_fault, rd_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13", "strobes after reset", {27'b0, push_valid, done, gp_fault, ss_fault, rd_en}, 32'd0);

        // R2 real mode, 16-bit, error code flagged but not written, limit ignored
        defaults(); kind = 0; has_err = 1; cs_limit = 32'd0; go("R2", 0);
        // R3 real mode, 32-bit, fault sets bit 16
        defaults(); kind = 0; op32 = 1; is_fault = 1; vector = 8'hFE; go("R3", 0);
        // R4 same level, 32-bit, interrupt gate, error code
        defaults(); kind = 1; op32 = 1; has_err = 1; is_fault = 1; go("R4", 0);
        // R4 same level, 16-bit, trap gate keeps IF
        defaults(); kind = 1; intr_gate = 0; old_flags = 32'h0000_4302; go("R4", 0);
        // R4 kind 3 behaves as same level
        defaults(); kind = 3; cur_cpl = 2'd1; go("R4", 0);
        // R5 more privileged, 32-bit, error code
        defaults(); kind = 2; op32 = 1; has_err = 1; tgt_dpl = 2'd1; go("R5", 0);
        // R5 R10 virtual-8086 entry, 32-bit, no error code
        defaults(); kind = 2; op32 = 1; from_v86 = 1; go("R5", 0);
        // R11 virtual-8086 entry, 16-bit, error code, trap gate
        defaults(); kind = 2; from_v86 = 1; has_err = 1; intr_gate = 0; tgt_dpl = 2'd2; go("R11", 0);
        // R6 stack room: one step short, then exactly enough
        defaults(); kind = 1; op32 = 1; has_err = 1; old_sp = 32'd12; go("R6", 0);
        defaults(); kind = 1; op32 = 1; has_err = 1; old_sp = 32'd16; go("R6", 0);
        defaults(); kind = 2; from_v86 = 1; new_sp = 32'd17; go("R6", 0);
        defaults(); kind = 0; old_sp = 32'd5; go("R6", 0);
        // R7 code limit: one above, then equal
        defaults(); kind = 1; gate_ip = 32'h0000_1001; cs_limit = 32'h0000_1000; go("R7", 0);
        defaults(); kind = 2; gate_ip = 32'h0000_1000; cs_limit = 32'h0000_1000; go("R7", 0);
        // R6 over R7 priority
        defaults(); kind = 2; new_sp = 32'd4; gate_ip = 32'hFFFF_FFFF; cs_limit = 32'd0; go("R6", 0);
        // R13 start and input changes mid-frame ignored
        defaults(); kind = 2; op32 = 1; from_v86 = 1; has_err = 1; go("R13", 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule